// File: doc/BRIEF.md
# Power-Up Challenge-Response Authentication Sequencer

This block decides whether the logic around it may run. It waits for the device to report that configuration has finished. It then runs one authentication exchange with an external secure memory and, alongside it, computes the expected answer locally. Normal function stays off until the exchange ends with a match. Any mismatch, or any step that never answers, leaves the block latched in a fault state until the next reset.

The block talks to the memory link through a request/acknowledge port that carries a command code and a byte index. The serial protocol behind that port is outside this block. A second request/done port drives an external hash engine. The block builds a 64-bit challenge from a free-running LFSR. It reads the memory's unique ID, writes the challenge, and tells the memory to compute its keyed digest. It then hashes the same inputs with its own secret key and reads the memory's 20-byte digest. Each received byte is XORed against the expected byte, and the result is folded into a sticky mismatch flag.

An optional per-device key mode runs a derivation hash before the challenge is written. That hash takes the master key, the memory ID and a derivation constant. After a pass, one feature byte is read from the memory and driven out as per-function enables.

Top module: `auth_seq`

## Requirements
- R1: While in reset, and after reset until `cfg_done_i` is seen high, `link_req_o`, `hash_req_o`, `func_en_o`, `fault_o` and `feat_en_o` are all 0.
- R2: Link commands are issued in this fixed order, with no other commands in between:
  - 8 ID reads (code 0, index 0..7);
  - 8 challenge writes (code 1, index 0..7);
  - 1 compute command (code 2);
  - the local digest hash request;
  - 20 digest reads (code 3, index 0..19).

  Link and hash requests are never active together. A link request holds its command and index until it is acknowledged.
- R3: Each run's challenge is the value of a free-running 64-bit maximal-length LFSR, captured when the run starts. The challenge is never zero, and runs started on different cycles after reset send different challenges.
- R4: The local digest request (`hash_mode_o`=0) presents the following, and the returned 160-bit digest is the expected response:
  - the working key;
  - the exact challenge written to the memory;
  - the ID read from the memory, with byte index 0 as bits 7:0;
  - the MAC constant.
- R5: When all 20 received bytes equal the expected bytes (byte i = digest bits 8i+7:8i), `func_en_o` goes to 1 and `fault_o` stays 0.
- R6: A mismatch in any single byte, including byte 0 or byte 19, drives `fault_o` to 1 with `func_en_o` at 0.
- R7: With `derive_mode_i`=1 at start, a derivation hash (`hash_mode_o`=1) runs right after the 8 ID reads. It presents the master key, the ID, a zero challenge and the derivation constant. Bits 63:0 of its result become the key for the local digest.
- R8: After a pass, one feature read (code 4) is issued, and `feat_en_o` equals the returned byte. `feat_en_o` is 0 whenever `func_en_o` is 0.
- R9: `hash_key_o` is 0 in every cycle in which `hash_req_o` is 0.
- R10: If a link or hash request goes unanswered for `TIMEOUT_CYC` cycles, the block ends in the fault state.
- R11: The pass or fault verdict holds until reset. Later changes on `cfg_done_i` start no new link traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_done_i | input | 1 | Configuration finished; starts the run |
| derive_mode_i | input | 1 | Per-device key mode, sampled at start |
| link_req_o | output | 1 | Memory link request |
| link_cmd_o | output | 3 | Link command code |
| link_idx_o | output | 5 | Byte index of the request |
| link_wdata_o | output | 8 | Challenge byte for write commands |
| link_ack_i | input | 1 | One-cycle acknowledge from the link |
| link_rdata_i | input | 8 | Read byte, valid with the acknowledge |
| hash_req_o | output | 1 | Hash engine request |
| hash_mode_o | output | 1 | 1 = key derivation, 0 = response digest |
| hash_key_o | output | 64 | Key operand, zero when idle |
| hash_chal_o | output | 64 | Challenge operand |
| hash_id_o | output | 64 | Memory ID operand |
| hash_const_o | output | 32 | Constant operand |
| hash_done_i | input | 1 | One-cycle completion from the hash engine |
| hash_digest_i | input | 160 | Digest, valid with done |
| func_en_o | output | 1 | Normal function enable |
| fault_o | output | 1 | Authentication failed |
| feat_en_o | output | 8 | Per-function enables after a pass |

## Verification
The hardest case to reach from the ports is a digest that differs from the expected one in exactly one byte, especially the last one. The sticky flag must still catch it after nineteen good bytes. The memory stub therefore computes a correct digest and flips one bit in a chosen byte index (0 or 19) as it returns it. A second hard case is a memory that holds the master key while the block expects a derived one. That case appears only when derivation runs and feeds the second hash, so the table covers both key choices in both modes.

// File: rtl/auth_seq_pkg.sv
package auth_seq_pkg;

  typedef enum logic [2:0] {
    LCMD_RD_ID    = 3'd0,
    LCMD_WR_CHAL  = 3'd1,
    LCMD_COMPUTE  = 3'd2,
    LCMD_RD_MAC   = 3'd3,
    LCMD_RD_FEAT  = 3'd4,
    LCMD_NONE     = 3'd7
  } link_cmd_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RD_ID,
    S_DERIVE,
    S_WR_CHAL,
    S_COMPUTE,
    S_LOCAL,
    S_RD_MAC,
    S_JUDGE,
    S_RD_FEAT,
    S_PASS,
    S_FAIL
  } auth_state_e;

endpackage

// File: rtl/auth_chal_lfsr.sv
module auth_chal_lfsr #(
  parameter int unsigned     W    = 64,
  parameter logic [W-1:0]    TAPS = 64'hD800_0000_0000_0000,
  parameter logic [W-1:0]    SEED = 64'h0123_4567_89AB_CDEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] state_o
);

  logic [W-1:0] lfsr_q, lfsr_d;
  logic         fb;

  always_comb begin
    fb = ^(lfsr_q & TAPS);
    lfsr_d = {lfsr_q[W-2:0], fb};
    // the lock-up state is unreachable from a nonzero seed; recover anyway
    if (lfsr_q == '0) lfsr_d = (SEED == '0) ? {{(W-1){1'b0}}, 1'b1} : SEED;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= (SEED == '0) ? {{(W-1){1'b0}}, 1'b1} : SEED;
    else         lfsr_q <= lfsr_d;
  end

  assign state_o = lfsr_q;

endmodule

// File: rtl/auth_step_timer.sv
module auth_step_timer #(
  parameter int unsigned TIMEOUT_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic expired_o
);

  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expired_o = run_i && (cnt_q == CNT_W'(TIMEOUT_CYC));

  always_comb begin
    cnt_en = 1'b1;
    if (clr_i || !run_i)  cnt_d = '0;
    else if (expired_o) begin
      cnt_d  = cnt_q;
      cnt_en = 1'b0;
    end else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/auth_byte_cmp.sv
module auth_byte_cmp #(
  parameter int unsigned NBYTES = 20,
  parameter int unsigned IDX_W  = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                vld_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [NBYTES*8-1:0] exp_i,
  input  logic [7:0]          rx_i,
  output logic                mismatch_o
);

  logic [NBYTES-1:0] lane_diff;
  logic              sel_diff;
  logic              mm_q, mm_d;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lane_diff[g] = |(exp_i[g*8 +: 8] ^ rx_i);
  end

  always_comb begin
    sel_diff = 1'b1;
    for (int i = 0; i < NBYTES; i++) begin
      if (idx_i == IDX_W'(i)) sel_diff = lane_diff[i];
    end
  end

  always_comb begin
    mm_d = mm_q;
    if (clr_i)      mm_d = 1'b0;
    else if (vld_i) mm_d = mm_q | sel_diff;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mm_q <= 1'b0;
    else         mm_q <= mm_d;
  end

  assign mismatch_o = mm_q;

endmodule

// File: rtl/auth_seq.sv
module auth_seq
  import auth_seq_pkg::*;
#(
  parameter int unsigned KEY_W       = 64,
  parameter int unsigned ID_W        = 64,
  parameter int unsigned CHAL_W      = 64,
  parameter int unsigned MAC_BYTES   = 20,
  parameter int unsigned CONST_W     = 32,
  parameter int unsigned TIMEOUT_CYC = 64,
  parameter logic [CHAL_W-1:0]  LFSR_TAPS  = 64'hD800_0000_0000_0000,
  parameter logic [CHAL_W-1:0]  LFSR_SEED  = 64'h0123_4567_89AB_CDEF,
  parameter logic [KEY_W-1:0]   MASTER_KEY = 64'h5A17_C0DE_93E1_4B2F,
  parameter logic [CONST_W-1:0] MAC_CONST  = 32'hA5C3_0F1E,
  parameter logic [CONST_W-1:0] DER_CONST  = 32'h3C96_E187
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_done_i,
  input  logic                   derive_mode_i,
  output logic                   link_req_o,
  output logic [2:0]             link_cmd_o,
  output logic [4:0]             link_idx_o,
  output logic [7:0]             link_wdata_o,
  input  logic                   link_ack_i,
  input  logic [7:0]             link_rdata_i,
  output logic                   hash_req_o,
  output logic                   hash_mode_o,
  output logic [KEY_W-1:0]       hash_key_o,
  output logic [CHAL_W-1:0]      hash_chal_o,
  output logic [ID_W-1:0]        hash_id_o,
  output logic [CONST_W-1:0]     hash_const_o,
  input  logic                   hash_done_i,
  input  logic [MAC_BYTES*8-1:0] hash_digest_i,
  output logic                   func_en_o,
  output logic                   fault_o,
  output logic [7:0]             feat_en_o
);

  localparam int unsigned DIG_W      = MAC_BYTES * 8;
  localparam int unsigned ID_BYTES   = ID_W / 8;
  localparam int unsigned CHAL_BYTES = CHAL_W / 8;
  localparam int unsigned IDX_W      = 5;

  auth_state_e          state_q, state_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [ID_W-1:0]      id_q, id_d;
  logic [CHAL_W-1:0]    chal_q, chal_d;
  logic [KEY_W-1:0]     key_q, key_d;
  logic [DIG_W-1:0]     exp_q, exp_d;
  logic [7:0]           feat_q, feat_d;
  logic                 derive_q, derive_d;
  logic                 gap_q, gap_d;

  logic [CHAL_W-1:0]    lfsr_q;
  logic                 tmo_hit;
  logic                 mismatch;
  logic                 cmp_clr, cmp_vld;
  logic                 link_hit, hash_hit;
  logic                 link_phase, hash_phase;

  // ---------------------------------------------------------------- challenge
  auth_chal_lfsr #(
    .W    (CHAL_W),
    .TAPS (LFSR_TAPS),
    .SEED (LFSR_SEED)
  ) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_o (lfsr_q)
  );

  // ---------------------------------------------------------------- timeout
  auth_step_timer #(
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (link_req_o | hash_req_o),
    .clr_i     (link_hit | hash_hit),
    .expired_o (tmo_hit)
  );

  // ---------------------------------------------------------------- compare
  auth_byte_cmp #(
    .NBYTES (MAC_BYTES),
    .IDX_W  (IDX_W)
  ) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (cmp_clr),
    .vld_i      (cmp_vld),
    .idx_i      (idx_q),
    .exp_i      (exp_q),
    .rx_i       (link_rdata_i),
    .mismatch_o (mismatch)
  );

  // ---------------------------------------------------------------- outputs
  always_comb begin
    link_phase = 1'b0;
    hash_phase = 1'b0;
    link_cmd_o = LCMD_NONE;
    unique case (state_q)
      S_RD_ID:   begin link_phase = 1'b1; link_cmd_o = LCMD_RD_ID;   end
      S_WR_CHAL: begin link_phase = 1'b1; link_cmd_o = LCMD_WR_CHAL; end
      S_COMPUTE: begin link_phase = 1'b1; link_cmd_o = LCMD_COMPUTE; end
      S_RD_MAC:  begin link_phase = 1'b1; link_cmd_o = LCMD_RD_MAC;  end
      S_RD_FEAT: begin link_phase = 1'b1; link_cmd_o = LCMD_RD_FEAT; end
      S_DERIVE,
      S_LOCAL:   hash_phase = 1'b1;
      default:   ;
    endcase
  end

  assign link_req_o   = link_phase & ~gap_q;
  assign hash_req_o   = hash_phase & ~gap_q;
  assign link_idx_o   = link_phase ? idx_q : '0;
  assign link_wdata_o = (state_q == S_WR_CHAL) ? chal_q[{idx_q, 3'b000} +: 8] : 8'h00;

  assign hash_mode_o  = (state_q == S_DERIVE);
  assign hash_key_o   = hash_req_o ? key_q : '0;
  assign hash_chal_o  = (state_q == S_LOCAL) ? chal_q : '0;
  assign hash_id_o    = hash_phase ? id_q : '0;
  assign hash_const_o = (state_q == S_DERIVE) ? DER_CONST : MAC_CONST;

  assign func_en_o    = (state_q == S_PASS);
  assign fault_o      = (state_q == S_FAIL);
  assign feat_en_o    = func_en_o ? feat_q : 8'h00;

  assign link_hit     = link_req_o & link_ack_i;
  assign hash_hit     = hash_req_o & hash_done_i;

  // ---------------------------------------------------------------- next state
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    id_d     = id_q;
    chal_d   = chal_q;
    key_d    = key_q;
    exp_d    = exp_q;
    feat_d   = feat_q;
    derive_d = derive_q;
    gap_d    = 1'b0;
    cmp_clr  = 1'b0;
    cmp_vld  = 1'b0;

    if (tmo_hit) begin
      state_d = S_FAIL;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (cfg_done_i) begin
            chal_d   = lfsr_q;
            derive_d = derive_mode_i;
            idx_d    = '0;
            cmp_clr  = 1'b1;
            state_d  = S_RD_ID;
          end
        end
        S_RD_ID: begin
          if (link_hit) begin
            id_d[{idx_q, 3'b000} +: 8] = link_rdata_i;
            gap_d = 1'b1;
            if (idx_q == IDX_W'(ID_BYTES - 1)) begin
              idx_d   = '0;
              state_d = derive_q ? S_DERIVE : S_WR_CHAL;
            end else begin
              idx_d = idx_q + IDX_W'(1);
            end
          end
        end
        S_DERIVE: begin
          if (hash_hit) begin
            key_d   = hash_digest_i[KEY_W-1:0];
            gap_d   = 1'b1;
            state_d = S_WR_CHAL;
          end
        end
        S_WR_CHAL: begin
          if (link_hit) begin
            gap_d = 1'b1;
            if (idx_q == IDX_W'(CHAL_BYTES - 1)) begin
              idx_d   = '0;
              state_d = S_COMPUTE;
            end else begin
              idx_d = idx_q + IDX_W'(1);
            end
          end
        end
        S_COMPUTE: begin
          if (link_hit) begin
            gap_d   = 1'b1;
            state_d = S_LOCAL;
          end
        end
        S_LOCAL: begin
          if (hash_hit) begin
            exp_d   = hash_digest_i;
            gap_d   = 1'b1;
            idx_d   = '0;
            state_d = S_RD_MAC;
          end
        end
        S_RD_MAC: begin
          if (link_hit) begin
            cmp_vld = 1'b1;
            gap_d   = 1'b1;
            if (idx_q == IDX_W'(MAC_BYTES - 1)) begin
              idx_d   = '0;
              state_d = S_JUDGE;
            end else begin
              idx_d = idx_q + IDX_W'(1);
            end
          end
        end
        S_JUDGE: begin
          state_d = mismatch ? S_FAIL : S_RD_FEAT;
        end
        S_RD_FEAT: begin
          if (link_hit) begin
            feat_d  = link_rdata_i;
            gap_d   = 1'b1;
            state_d = S_PASS;
          end
        end
        S_PASS:  ;
        S_FAIL:  ;
        default: state_d = S_FAIL;
      endcase
    end
  end

  // ---------------------------------------------------------------- registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      idx_q    <= '0;
      id_q     <= '0;
      chal_q   <= '0;
      key_q    <= MASTER_KEY;
      exp_q    <= '0;
      feat_q   <= '0;
      derive_q <= 1'b0;
      gap_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      id_q     <= id_d;
      chal_q   <= chal_d;
      key_q    <= key_d;
      exp_q    <= exp_d;
      feat_q   <= feat_d;
      derive_q <= derive_d;
      gap_q    <= gap_d;
    end
  end

endmodule

// File: rtl/auth_seq_chk.sv
module auth_seq_chk #(
  parameter int unsigned KEY_W  = 64,
  parameter int unsigned CHAL_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              link_req_o,
  input logic              link_ack_i,
  input logic [2:0]        link_cmd_o,
  input logic [4:0]        link_idx_o,
  input logic              hash_req_o,
  input logic [KEY_W-1:0]  hash_key_o,
  input logic              func_en_o,
  input logic              fault_o,
  input logic [7:0]        feat_en_o,
  input logic [CHAL_W-1:0] lfsr_q,
  input logic              tmo_hit
);

  assert_verdict_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(func_en_o && fault_o));

  assert_pass_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    func_en_o |=> func_en_o);

  assert_fault_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o);

  assert_feat_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (feat_en_o != 8'h00) |-> func_en_o);

  assert_key_hidden_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hash_req_o |-> (hash_key_o == '0));

  assert_one_port_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(link_req_o && hash_req_o));

  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_req_o && !link_ack_i && !tmo_hit) |=>
      (link_req_o && $stable(link_cmd_o) && $stable(link_idx_o)));

  assert_lfsr_live_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);

  assert_quiet_verdict_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func_en_o || fault_o) |-> !link_req_o && !hash_req_o);

endmodule

bind auth_seq auth_seq_chk #(
  .KEY_W  (KEY_W),
  .CHAL_W (CHAL_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .link_req_o (link_req_o),
  .link_ack_i (link_ack_i),
  .link_cmd_o (link_cmd_o),
  .link_idx_o (link_idx_o),
  .hash_req_o (hash_req_o),
  .hash_key_o (hash_key_o),
  .func_en_o  (func_en_o),
  .fault_o    (fault_o),
  .feat_en_o  (feat_en_o),
  .lfsr_q     (lfsr_q),
  .tmo_hit    (tmo_hit)
);

// File: tb/auth_seq_tb_top.sv
`timescale 1ns/1ps
module auth_seq_tb_top;

  localparam logic [63:0] TB_MASTER = 64'h5A17_C0DE_93E1_4B2F;
  localparam logic [31:0] TB_MACC   = 32'hA5C3_0F1E;
  localparam logic [31:0] TB_DERC   = 32'h3C96_E187;
  localparam int          TB_TMO    = 64;
  localparam int          LAT       = 3;

  typedef struct packed {
    logic       derive;
    logic       keygood;
    logic       cor_en;
    logic [4:0] cor_idx;
    logic [7:0] feat;
    logic [7:0] delay;
    logic       pass;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, 1'b0, 5'd0,  8'hA5, 8'd3,  1'b1},
    '{1'b0, 1'b0, 1'b0, 5'd0,  8'h3C, 8'd10, 1'b0},
    '{1'b0, 1'b1, 1'b1, 5'd19, 8'h11, 8'd17, 1'b0},
    '{1'b0, 1'b1, 1'b1, 5'd0,  8'h22, 8'd24, 1'b0},
    '{1'b1, 1'b1, 1'b0, 5'd0,  8'h5A, 8'd31, 1'b1},
    '{1'b1, 1'b0, 1'b0, 5'd0,  8'h77, 8'd40, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_done, derive_mode;
  logic         link_req, link_ack;
  logic [2:0]   link_cmd;
  logic [4:0]   link_idx;
  logic [7:0]   link_wdata, link_rdata;
  logic         hash_req, hash_mode, hash_done;
  logic [63:0]  hash_key, hash_chal, hash_id;
  logic [31:0]  hash_const;
  logic [159:0] hash_dig;
  logic         func_en, fault;
  logic [7:0]   feat_en;

  always #4 clk = ~clk;

  auth_seq #(
    .TIMEOUT_CYC (TB_TMO),
    .MASTER_KEY  (TB_MASTER),
    .MAC_CONST   (TB_MACC),
    .DER_CONST   (TB_DERC)
  ) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .cfg_done_i    (cfg_done),
    .derive_mode_i (derive_mode),
    .link_req_o    (link_req),
    .link_cmd_o    (link_cmd),
    .link_idx_o    (link_idx),
    .link_wdata_o  (link_wdata),
    .link_ack_i    (link_ack),
    .link_rdata_i  (link_rdata),
    .hash_req_o    (hash_req),
    .hash_mode_o   (hash_mode),
    .hash_key_o    (hash_key),
    .hash_chal_o   (hash_chal),
    .hash_id_o     (hash_id),
    .hash_const_o  (hash_const),
    .hash_done_i   (hash_done),
    .hash_digest_i (hash_dig),
    .func_en_o     (func_en),
    .fault_o       (fault),
    .feat_en_o     (feat_en)
  );

  int checks = 0;
  int fails  = 0;

  function automatic logic [159:0] toy_hash(input logic [63:0] k, input logic [63:0] c,
                                            input logic [63:0] id, input logic [31:0] cst);
    logic [159:0] r;
    for (int i = 0; i < 20; i++) begin
      r[i*8 +: 8] = k[(i%8)*8 +: 8] ^ c[((i+3)%8)*8 +: 8] ^ id[((i+5)%8)*8 +: 8]
                  ^ cst[(i%4)*8 +: 8] ^ 8'(i*37);
    end
    return r;
  endfunction

  // ---------------------------------------------------------------- memory stub
  logic [63:0]  mem_id, mem_key, mem_chal;
  logic [159:0] mem_mac;
  logic [7:0]   mem_feat;
  logic         mem_mute, cor_en;
  logic [4:0]   cor_idx;
  int           lcnt;
  int           log_n;
  logic [2:0]   cmd_log [64];
  logic [4:0]   idx_log [64];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_ack   <= 1'b0;
      link_rdata <= 8'h00;
      lcnt       <= 0;
      log_n      <= 0;
      mem_chal   <= 64'h0;
      mem_mac    <= '0;
    end else begin
      link_ack <= 1'b0;
      if (link_ack) lcnt <= 0;
      else if (link_req && !mem_mute) begin
        if (lcnt == LAT - 1) begin
          link_ack <= 1'b1;
          lcnt     <= 0;
          if (log_n < 64) begin
            cmd_log[log_n] <= link_cmd;
            idx_log[log_n] <= link_idx;
          end
          log_n <= log_n + 1;
          case (link_cmd)
            3'd0: link_rdata <= mem_id[link_idx*8 +: 8];
            3'd1: mem_chal[link_idx*8 +: 8] <= link_wdata;
            3'd2: mem_mac <= toy_hash(mem_key, mem_chal, mem_id, TB_MACC);
            3'd3: link_rdata <= mem_mac[link_idx*8 +: 8]
                              ^ ((cor_en && link_idx == cor_idx) ? 8'h01 : 8'h00);
            3'd4: link_rdata <= mem_feat;
            default: link_rdata <= 8'h00;
          endcase
        end else lcnt <= lcnt + 1;
      end else lcnt <= 0;
    end
  end

  // ---------------------------------------------------------------- hash stub
  logic        hash_mute;
  int          hcnt;
  int          mac_at, der_at;
  logic [63:0] seen_chal, seen_id, seen_key;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hash_done <= 1'b0;
      hash_dig  <= '0;
      hcnt      <= 0;
      mac_at    <= -1;
      der_at    <= -1;
      seen_chal <= '0;
      seen_id   <= '0;
      seen_key  <= '0;
    end else begin
      hash_done <= 1'b0;
      if (hash_done) hcnt <= 0;
      else if (hash_req && !hash_mute) begin
        if (hcnt == LAT - 1) begin
          hash_done <= 1'b1;
          hcnt      <= 0;
          hash_dig  <= toy_hash(hash_key, hash_chal, hash_id, hash_const);
          if (hash_mode) der_at <= log_n;
          else begin
            mac_at    <= log_n;
            seen_chal <= hash_chal;
            seen_id   <= hash_id;
            seen_key  <= hash_key;
          end
        end else hcnt <= hcnt + 1;
      end else hcnt <= 0;
    end
  end

  // R9 monitor: key operand must read zero outside requests
  int key_leak = 0;
  always @(negedge clk) begin
    if (rst_n && !hash_req && hash_key != 64'h0) key_leak <= key_leak + 1;
  end

  // ---------------------------------------------------------------- helpers
  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    cfg_done = 1'b0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_verdict(input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (func_en || fault) break;
    end
  endtask

  logic [63:0] prev_chal;

  task automatic run_vec(input int n, input vec_t v);
    logic [63:0] derived;
    int          exp_n, bad;
    mem_id      = 64'h1122_3344_5566_7788 ^ (64'(n) * 64'h0F0E_0D0C_0B0A_0908);
    mem_feat    = v.feat;
    derived     = toy_hash(TB_MASTER, 64'h0, mem_id, TB_DERC)[63:0];
    if (v.derive) mem_key = v.keygood ? derived : TB_MASTER;
    else          mem_key = v.keygood ? TB_MASTER : (TB_MASTER ^ 64'h1);
    cor_en      = v.cor_en;
    cor_idx     = v.cor_idx;
    derive_mode = v.derive;
    mem_mute    = 1'b0;
    hash_mute   = 1'b0;
    do_reset();
    repeat (int'(v.delay)) @(negedge clk);
    cfg_done = 1'b1;
    wait_verdict(600);

    if (v.pass) chk(func_en && !fault, v.derive ? "R7 pass" : "R5 pass",
                    {62'h0, func_en, fault}, 64'h2);
    else        chk(fault && !func_en, v.derive ? "R7 fail" : "R6 fail",
                    {62'h0, func_en, fault}, 64'h1);
    chk(feat_en == (v.pass ? v.feat : 8'h00), "R8 feature enables",
        64'(feat_en), 64'(v.pass ? v.feat : 8'h00));

    exp_n = 37 + (v.pass ? 1 : 0);
    chk(log_n == exp_n, "R2 command count", 64'(log_n), 64'(exp_n));
    bad = 0;
    for (int i = 0; i < exp_n && i < 64; i++) begin
      logic [2:0] ec;
      logic [4:0] ei;
      if (i < 8)       begin ec = 3'd0; ei = 5'(i);      end
      else if (i < 16) begin ec = 3'd1; ei = 5'(i - 8);  end
      else if (i < 17) begin ec = 3'd2; ei = 5'd0;       end
      else if (i < 37) begin ec = 3'd3; ei = 5'(i - 17); end
      else             begin ec = 3'd4; ei = 5'd0;       end
      if (cmd_log[i] != ec || (ec != 3'd2 && ec != 3'd4 && idx_log[i] != ei)) bad++;
    end
    chk(bad == 0, "R2 command order", 64'(bad), 64'h0);
    chk(mac_at == 17, "R2 local hash after compute", 64'(mac_at), 64'd17);
    chk(der_at == (v.derive ? 8 : -1), "R7 derivation slot", 64'(der_at),
        64'(v.derive ? 8 : -1));
    chk(seen_key == (v.derive ? derived : TB_MASTER), "R7 working key",
        seen_key, v.derive ? derived : TB_MASTER);
    chk(seen_chal == mem_chal, "R4 hash challenge", seen_chal, mem_chal);
    chk(seen_id == mem_id, "R4 hash id", seen_id, mem_id);
    chk(mem_chal != 64'h0 && mem_chal != prev_chal, "R3 fresh challenge",
        mem_chal, ~prev_chal);
    prev_chal = mem_chal;
  endtask

  // ---------------------------------------------------------------- watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired checks=%0d", checks);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // ---------------------------------------------------------------- main
  initial begin
    int busy;
    rst_n       = 1'b0;
    cfg_done    = 1'b0;
    derive_mode = 1'b0;
    mem_mute    = 1'b0;
    hash_mute   = 1'b0;
    cor_en      = 1'b0;
    cor_idx     = 5'd0;
    mem_id      = 64'h0;
    mem_key     = 64'h0;
    mem_feat    = 8'h00;
    prev_chal   = 64'h0;

    // R1: reset and pre-start quiet state
    @(negedge clk);
    chk(!link_req && !hash_req && !func_en && !fault && feat_en == 8'h00,
        "R1 reset outputs", {59'h0, link_req, hash_req, func_en, fault, |feat_en}, 64'h0);
    rst_n = 1'b1;
    busy = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (link_req || hash_req || func_en || fault) busy++;
    end
    chk(busy == 0, "R1 idle before cfg_done", 64'(busy), 64'h0);

    // table-driven runs
    for (int n = 0; n < NVEC; n++) run_vec(n, VECS[n]);

    // R11: verdict held, no restart on cfg_done activity
    run_vec(6, VECS[0]);
    cfg_done = 1'b0;
    repeat (5) @(negedge clk);
    cfg_done = 1'b1;
    busy = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (link_req || hash_req) busy++;
    end
    chk(busy == 0 && func_en, "R11 no restart after pass", 64'(busy), 64'h0);

    // R10: memory link never answers
    mem_mute = 1'b1;
    do_reset();
    cfg_done = 1'b1;
    wait_verdict(400);
    chk(fault && !func_en, "R10 link timeout", {62'h0, func_en, fault}, 64'h1);
    chk(log_n == 0, "R10 no link traffic", 64'(log_n), 64'h0);

    // R10: hash engine never answers
    mem_mute    = 1'b0;
    hash_mute   = 1'b1;
    derive_mode = 1'b0;
    do_reset();
    cfg_done = 1'b1;
    wait_verdict(600);
    chk(fault && !func_en, "R10 hash timeout", {62'h0, func_en, fault}, 64'h1);
    chk(log_n == 17, "R10 stop before digest read", 64'(log_n), 64'd17);
    hash_mute = 1'b0;

    // R9: key operand never visible outside hash requests
    chk(key_leak == 0, "R9 key hidden", 64'(key_leak), 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule